// File: doc/BRIEF.md
# ALU Status Flag Generator

This unit carries out one arithmetic or logic operation per accepted request on two 16-bit operands. The operations are add, subtract, AND, OR, XOR and NOT, each in either 8-bit or 16-bit width. It registers the result and keeps a 16-bit flag word. Six condition flags follow from each arithmetic or logic result: carry, auxiliary carry, parity, zero, sign and overflow. Three control flags (trap, interrupt enable, direction) change only through dedicated set and clear inputs.

In byte mode only the low byte of each operand takes part. The result's upper byte reads as zero, and carry, overflow, sign and zero are formed at bit 7. In both modes parity is always taken from the low result byte. The execution logic that surrounds the unit presents an operation with `op_valid`. Both the result and the flags appear on the outputs one clock edge later.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `result` and `flags` are both zero until an operation or a control write occurs.
- R2: With `op_valid` high, `op_sel` selects the operation: 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR, 5 NOT (of a). `result` shows the outcome after the next rising edge. When `byte_mode` is high, `result[15:8]` is zero and only the low operand bytes are used.
- R3: Carry (`flags[0]`) is set for add on an unsigned carry out of the top bit (bit 7 in byte mode, bit 15 otherwise). For subtract it is set on a borrow, which means unsigned a is less than unsigned b.
- R4: Auxiliary carry (`flags[1]`) is set by add on a carry from bit 3 into bit 4, and by subtract on a borrow from bit 4 into bit 3.
- R5: Parity (`flags[2]`) is 1 when `result[7:0]` holds an even number of ones and 0 when it holds an odd number, in either width.
- R6: Zero (`flags[3]`) is 1 exactly when the result of the operation is zero.
- R7: Sign (`flags[4]`) equals the top bit of the result: bit 7 in byte mode, bit 15 otherwise.
- R8: Overflow (`flags[5]`) is set for add when both operands share a sign and the result's sign differs. For subtract it is set when the operands differ in sign and the result's sign differs from a.
- R9: AND, OR and XOR clear carry, auxiliary carry and overflow, and update parity, zero and sign.
- R10: NOT writes the inverted a to `result` and leaves all of `flags` unchanged.
- R11: `ctl_set[i]` sets and `ctl_clr[i]` clears control flag i on the next edge. If both are high, set wins. Bit 0 maps to trap at `flags[8]`, bit 1 to interrupt enable at `flags[9]`, and bit 2 to direction at `flags[10]`. No operation ever changes these three bits.
- R12: When `op_valid` is low, or when `op_sel` is 6 or 7, `result` and `flags[5:0]` keep their values.
- R13: Flag bits 6, 7 and 15:11 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept the operation on this edge |
| op_sel | input | 3 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit width |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| ctl_set | input | 3 | Per control flag set strobe |
| ctl_clr | input | 3 | Per control flag clear strobe |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flag word |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge once reset is released. They also assume that `byte_mode` and `op_sel` remain valid for the cycle in which `op_valid` is high. No protocol rule applies between operations, so reserved codes and strobes that overlap with operations are both legal. The stimulus changes inputs only on falling edges. Each operation is held for exactly one cycle and then dropped, and every value driven is fully defined, including the reserved op codes and set/clear strobes that occur together.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_sel,
  input  logic        byte_mode,
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic [2:0]  ctl_set,
  input  logic [2:0]  ctl_clr,
  output logic [15:0] result,
  output logic [15:0] flags
);
  localparam int CF = 0, AF = 1, PF = 2, ZF = 3, SF = 4, OF = 5;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2,
                         OP_OR  = 3'd3, OP_XOR = 3'd4, OP_NOT = 3'd5;

  logic        is_sub, is_arith, is_logic, is_not;
  logic [15:0] bx, raw, res;
  logic [16:0] sum;
  logic        msb_a, msb_b, msb_r, cout, c4;
  logic [5:0]  st_next, st_q;
  logic [2:0]  ctl_q;

  assign is_sub   = (op_sel == OP_SUB);
  assign is_arith = (op_sel == OP_ADD) || is_sub;
  assign is_logic = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_XOR);
  assign is_not   = (op_sel == OP_NOT);

  assign bx  = is_sub ? ~b : b;
  assign sum = {1'b0, a} + {1'b0, bx} + {16'd0, is_sub};

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: raw = sum[15:0];
      OP_AND:         raw = a & b;
      OP_OR:          raw = a | b;
      OP_XOR:         raw = a ^ b;
      OP_NOT:         raw = ~a;
      default:        raw = result;
    endcase
  end

  assign res   = byte_mode ? {8'h00, raw[7:0]} : raw;
  assign msb_a = byte_mode ? a[7]   : a[15];
  assign msb_b = byte_mode ? bx[7]  : bx[15];
  assign msb_r = byte_mode ? res[7] : res[15];
  assign cout  = byte_mode ? (sum[8] ^ a[8] ^ bx[8]) : sum[16];
  assign c4    = sum[4] ^ a[4] ^ bx[4];

  always_comb begin
    st_next     = '0;
    st_next[CF] = is_arith & (cout ^ is_sub);
    st_next[AF] = is_arith & (c4 ^ is_sub);
    st_next[PF] = ~^res[7:0];
    st_next[ZF] = (res == 16'h0000);
    st_next[SF] = msb_r;
    st_next[OF] = is_arith & (msb_a == msb_b) & (msb_r != msb_a);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      st_q   <= '0;
      ctl_q  <= '0;
    end else begin
      if (op_valid && (is_arith || is_logic || is_not)) result <= res;
      if (op_valid && (is_arith || is_logic))           st_q   <= st_next;
      ctl_q <= (ctl_q & ~ctl_clr) | ctl_set;
    end
  end

  assign flags = {5'b00000, ctl_q, 2'b00, st_q};
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_sel,
  input logic        byte_mode,
  input logic [2:0]  ctl_set,
  input logic [2:0]  ctl_clr,
  input logic [15:0] result,
  input logic [15:0] flags
);
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags[10:8])); // R11
  AST_CTL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_set[0] |=> flags[8]); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_sel > 3'd5) |=> ($stable(result) && $stable(flags[5:0]))); // R12
  AST_NOT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 3'd5) |=> $stable(flags[5:0])); // R10
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && byte_mode && op_sel <= 3'd5) |=> (result[15:8] == 8'h00)); // R2
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= 3'd4) |=> (flags[3] == (result == 16'h0000))); // R6
  AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= 3'd4) |=> (flags[2] == ~^result[7:0])); // R5
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel >= 3'd2 && op_sel <= 3'd4) |=> (flags[5] == 1'b0 && flags[1:0] == 2'b00)); // R9
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= 3'd4) |=> (flags[4] == (byte_mode ? result[7] : result[15]))); // R7
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (.*);

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic        byte_mode = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic [15:0] result, flags;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  alu_flag_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {op[2:0], byte, a, b, expected result, expected flags[5:0] = O S Z P A C}
  localparam int NV = 16;
  localparam logic [57:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h0001, 16'h0002, 16'h0003, 6'h04},
    {3'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 6'h0F},
    {3'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 6'h36},
    {3'd1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 6'h17},
    {3'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 6'h26},
    {3'd0, 1'b1, 16'h12FF, 16'h3401, 16'h0000, 6'h0F},
    {3'd0, 1'b1, 16'h007F, 16'h0001, 16'h0080, 6'h32},
    {3'd1, 1'b1, 16'h0010, 16'h0020, 16'h00F0, 6'h15},
    {3'd1, 1'b0, 16'h1234, 16'h1234, 16'h0000, 6'h0C},
    {3'd2, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 6'h04},
    {3'd3, 1'b0, 16'h8000, 16'h0001, 16'h8001, 6'h10},
    {3'd4, 1'b0, 16'hAAAA, 16'hAAAA, 16'h0000, 6'h0C},
    {3'd4, 1'b1, 16'hFF83, 16'h0000, 16'h0083, 6'h10},
    {3'd2, 1'b1, 16'h0F00, 16'hFF00, 16'h0000, 6'h0C},
    {3'd0, 1'b0, 16'h0008, 16'h0008, 16'h0010, 6'h02},
    {3'd0, 1'b0, 16'h0100, 16'h0000, 16'h0100, 6'h04}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic bm, input logic [15:0] va, input logic [15:0] vb);
    @(negedge clk);
    op_sel = op; byte_mode = bm; a = va; b = vb; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic ctl_write(input logic [2:0] s, input logic [2:0] c);
    @(negedge clk);
    ctl_set = s; ctl_clr = c;
    @(negedge clk);
    ctl_set = '0; ctl_clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, 16'h0000);
    check("R1 flags in reset", flags, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after reset", result, 16'h0000);
    check("R1 flags after reset", flags, 16'h0000);

    // R2 R3 R4 R5 R6 R7 R8 R9 R13: table walk
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][57:55], VEC[i][54], VEC[i][53:38], VEC[i][37:22]);
      check($sformatf("R2 vec %0d result", i), result, VEC[i][21:6]);
      check($sformatf("R3-flags vec %0d (R3 R4 R5 R6 R7 R8 R9 R13)", i), flags, {10'd0, VEC[i][5:0]});
    end

    // R10: NOT keeps flags
    run_op(3'd0, 1'b0, 16'hFFFF, 16'h0001);
    run_op(3'd5, 1'b0, 16'h00F0, 16'h1234);
    check("R10 not word result", result, 16'hFF0F);
    check("R10 not keeps flags", flags, 16'h000F);
    run_op(3'd5, 1'b1, 16'h1234, 16'h0000);
    check("R10 not byte result", result, 16'h00CB);
    check("R10 not byte keeps flags", flags, 16'h000F);

    // R12: idle and reserved codes
    @(negedge clk);
    op_sel = 3'd1; a = 16'h5555; b = 16'h0001; byte_mode = 1'b0;
    @(negedge clk);
    check("R12 idle result", result, 16'h00CB);
    check("R12 idle flags", flags, 16'h000F);
    run_op(3'd6, 1'b0, 16'h0000, 16'h0000);
    check("R12 code 6 result", result, 16'h00CB);
    check("R12 code 6 flags", flags, 16'h000F);
    run_op(3'd7, 1'b0, 16'h0001, 16'h0000);
    check("R12 code 7 flags", flags, 16'h000F);

    // R11: control flags
    ctl_write(3'b001, 3'b000);
    check("R11 trap set", flags, 16'h010F);
    run_op(3'd2, 1'b0, 16'h0001, 16'h0001);
    check("R11 ctl kept across op", flags, 16'h0100);
    ctl_write(3'b110, 3'b000);
    check("R11 all set", flags, 16'h0700);
    ctl_write(3'b100, 3'b110);
    check("R11 set wins and clear int", flags, 16'h0500);
    @(negedge clk);
    check("R11 hold without strobe", flags, 16'h0500);
    ctl_write(3'b000, 3'b101);
    check("R11 clear trap and dir", flags, 16'h0000);

    // R1: reset mid-run
    ctl_write(3'b111, 3'b000);
    run_op(3'd0, 1'b0, 16'h7FFF, 16'h0001);
    check("R11 pre-reset flags", flags, 16'h0736);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset clears result", result, 16'h0000);
    check("R1 reset clears flags", flags, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule